// File: doc/BRIEF.md
# Tap Wiper Select Logic

This block drives the switch matrix of a resistor-string potentiometer with 2^CODE_W taps. It keeps a held wiper code and turns it into one enable line per tap. Bit 0 of the enable vector is the tap next to the low end of the string, and the top bit is the tap next to the high end. It also produces two end-terminal controls: one connects the high end of the string, the other shorts the wiper to the low end.

A register controller presents a code and a run/shutdown bit, then pulses a one-cycle update strobe after the write has been committed. Inputs are sampled only on that strobe. When the tap changes in normal operation, the new tap is enabled first and both taps stay on for a short overlap. Only after that is the old tap released. Shutdown removes every tap enable, disconnects the high terminal and shorts the wiper to the low terminal.

Top module: `tap_wiper_sel`

## Requirements
- R1: After reset, only enable bit 128 (the mid-scale code 80h) is set, hi_conn is 1 and wiper_short is 0.
- R2: Once an update has settled in normal operation, the single active enable bit has the index equal to the code, so code 00h enables bit 0 and code FFh enables bit 255.
- R3: An update in normal operation that carries a code different from the held one turns the new tap on in the cycle after the strobe. The old tap stays on with it for OVERLAP cycles (default 2). After that, only the new tap is on.
- R4: In normal operation, exactly one enable bit is set at all times except during an overlap, when exactly two are set.
- R5: An update with run = 0 clears every tap enable, drives hi_conn to 0 and drives wiper_short to 1 from the cycle after the strobe onward.
- R6: An update with run = 1 taken while in shutdown enables only the tap given by the new code in the next cycle, with no overlap, and sets hi_conn to 1 and wiper_short to 0.
- R7: Without an update strobe, changes on code and run have no effect on any output.
- R8: An update with a new code that arrives during an overlap replaces the pending target. The held tap stays on, and the overlap restarts with a full OVERLAP cycles.
- R9: An update in normal operation whose code equals the held code leaves only that tap on, and any overlap in progress is cancelled.
- R10: Whenever the set of tap enables changes in normal operation, at least one tap is on both before and after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| upd | input | 1 | One-cycle strobe: take code and run |
| code | input | CODE_W | Requested wiper code |
| run | input | 1 | 1 = normal operation, 0 = shutdown |
| tap_en | output | 2^CODE_W | Tap switch enables, bit 0 nearest the low terminal |
| hi_conn | output | 1 | Connects the high end of the string |
| wiper_short | output | 1 | Shorts the wiper to the low terminal |

## Verification
The hardest state to reach from the ports is a second update that lands inside an overlap window, because it only matters within OVERLAP cycles of the first update. A shutdown request in that same window is harder still. The stimulus places back-to-back strobes on purpose, including a shutdown during an overlap. Random traffic with a high strobe rate then repeats these collisions with a wide range of codes, while a bench model tracks the held tap, the pending target and the remaining overlap.

// File: rtl/tap_wiper_sel.sv
module tap_wiper_sel #(
  parameter int CODE_W  = 8,
  parameter int OVERLAP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic [CODE_W-1:0]        code,
  input  logic                     run,
  output logic [(1<<CODE_W)-1:0]   tap_en,
  output logic                     hi_conn,
  output logic                     wiper_short
);
  localparam int NTAPS = 1 << CODE_W;
  localparam int CNT_W = $clog2(OVERLAP + 1);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] cur, tgt;
  logic [CNT_W-1:0]  cnt;
  logic              ovl, shut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= MID;
      tgt  <= MID;
      cnt  <= '0;
      ovl  <= 1'b0;
      shut <= 1'b0;
    end else if (upd) begin
      if (!run) begin
        shut <= 1'b1;
        cur  <= code;
        ovl  <= 1'b0;
        cnt  <= '0;
      end else if (shut) begin
        shut <= 1'b0;
        cur  <= code;
        ovl  <= 1'b0;
        cnt  <= '0;
      end else if (code == cur) begin
        ovl  <= 1'b0;
        cnt  <= '0;
      end else begin
        tgt  <= code;
        ovl  <= 1'b1;
        cnt  <= CNT_W'(OVERLAP);
      end
    end else if (ovl) begin
      if (cnt == CNT_W'(1)) begin
        cur <= tgt;
        ovl <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    tap_en = '0;
    if (!shut) begin
      tap_en[cur] = 1'b1;
      if (ovl) tap_en[tgt] = 1'b1;
    end
  end

  assign hi_conn     = ~shut;
  assign wiper_short = shut;

  AST_SINGLE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_conn && !ovl) |-> ($countones(tap_en) == 1)); // R4
  AST_OVERLAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_conn && ovl) |-> ($countones(tap_en) == 2)); // R3
  AST_SHUT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_short |-> (tap_en == '0 && !hi_conn)); // R5
  AST_SHUT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !run) |=> (wiper_short && tap_en == '0)); // R5
  AST_MAKE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_conn && $past(hi_conn) && tap_en != $past(tap_en)) |-> ((tap_en & $past(tap_en)) != '0)); // R10
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !ovl) |=> ($stable(tap_en) && $stable(hi_conn))); // R7
endmodule

// File: tb/tap_wiper_sel_tb.sv
module tap_wiper_sel_tb;
  localparam int CODE_W  = 8;
  localparam int OVERLAP = 2;
  localparam int NTAPS   = 1 << CODE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic run = 1'b1;
  logic [NTAPS-1:0] tap_en;
  logic hi_conn, wiper_short;

  int checks = 0;
  int fails  = 0;

  // model state
  int  m_cur = 128, m_tgt = 128, m_cnt = 0;
  bit  m_ovl = 0, m_shut = 0;

  always #10 clk = ~clk;

  tap_wiper_sel #(.CODE_W(CODE_W), .OVERLAP(OVERLAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .upd(upd), .code(code), .run(run),
    .tap_en(tap_en), .hi_conn(hi_conn), .wiper_short(wiper_short));

  function automatic logic [NTAPS-1:0] exp_taps();
    logic [NTAPS-1:0] v = '0;
    if (!m_shut) begin
      v[m_cur] = 1'b1;
      if (m_ovl) v[m_tgt] = 1'b1;
    end
    return v;
  endfunction

  task automatic model_edge(bit u, int c, bit r);
    if (u) begin
      if (!r) begin m_shut = 1; m_cur = c; m_ovl = 0; m_cnt = 0; end
      else if (m_shut) begin m_shut = 0; m_cur = c; m_ovl = 0; m_cnt = 0; end
      else if (c == m_cur) begin m_ovl = 0; m_cnt = 0; end
      else begin m_tgt = c; m_ovl = 1; m_cnt = OVERLAP; end
    end else if (m_ovl) begin
      if (m_cnt == 1) begin m_cur = m_tgt; m_ovl = 0; m_cnt = 0; end
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic compare(string tag);
    logic [NTAPS-1:0] e = exp_taps();
    checks++;
    if (tap_en !== e || hi_conn !== !m_shut || wiper_short !== m_shut) begin
      fails++;
      $display("FAIL %s: tap_en=%h hi=%b sh=%b expected tap_en=%h hi=%b sh=%b",
               tag, tap_en, hi_conn, wiper_short, e, !m_shut, m_shut);
    end
  endtask

  task automatic cyc(bit u, int c, bit r, string tag);
    upd = u; code = CODE_W'(c); run = r;
    @(posedge clk);
    model_edge(u, c, r);
    @(negedge clk);
    upd = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    cyc(0, 0, 1, "R1");

    cyc(1, 8'h10, 1, "R3");
    cyc(0, 8'h10, 1, "R3");
    cyc(0, 8'h10, 1, "R2");
    cyc(0, 8'h10, 1, "R2");
    cyc(1, 8'hFF, 1, "R3");
    cyc(0, 0, 1, "R3");
    cyc(0, 0, 1, "R2");
    cyc(1, 8'h00, 1, "R3");
    cyc(0, 0, 1, "R3");
    cyc(0, 0, 1, "R2");

    cyc(0, 8'h77, 0, "R7");
    cyc(0, 8'h33, 1, "R7");
    cyc(1, 8'h00, 1, "R9");
    cyc(0, 0, 1, "R9");

    cyc(1, 8'h40, 1, "R8");
    cyc(1, 8'h41, 1, "R8");
    cyc(0, 0, 1, "R8");
    cyc(0, 0, 1, "R8");
    cyc(0, 0, 1, "R8");
    cyc(1, 8'h90, 1, "R9");
    cyc(1, 8'h41, 1, "R9");
    cyc(0, 0, 1, "R9");

    cyc(1, 8'h22, 0, "R5");
    cyc(0, 8'h99, 1, "R7");
    cyc(0, 8'h55, 0, "R7");
    cyc(1, 8'hA5, 1, "R6");
    cyc(0, 0, 1, "R6");
    cyc(1, 8'h05, 1, "R10");
    cyc(1, 8'h06, 0, "R5");
    cyc(0, 0, 1, "R5");
    cyc(1, 8'h06, 1, "R6");

    for (int i = 0; i < 3000; i++) begin
      bit u = ($urandom % 100) < 35;
      bit r = ($urandom % 100) < 88;
      int c = $urandom % NTAPS;
      cyc(u, c, r, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule